// File: doc/BRIEF.md
# Legacy Shadow Region Router

This block sits in the memory path of a host bridge and decides, for every CPU access that lands in the legacy area between 0xC0000 and 0xFFFFF, whether the access is served by main DRAM or by the ROM/firmware side of the bus. A bank of seven attribute bytes holds its settings. The bytes are reached through a byte-wide configuration port. Each byte carries two 4-bit region controls, so one byte governs two regions.

Each region has its own read-enable bit and its own write-enable bit. Firmware can therefore read an area from ROM while its writes already land in DRAM, which lets it copy itself into shadow RAM and then switch reads over. For reads that go to the ROM side, the block also gives the offset inside the firmware image. The top of the image appears just below 1 MB, in a window of at most 128 KB, and the whole image appears just below the top of the address space.

A routing decision is registered. It appears one clock after the request that caused it.

Top module: `shadow_attr_router`

## Requirements
- R1: After reset, all seven attribute bytes read 0x00. Every read or write inside 0xC0000–0xFFFFF is then routed to the ROM side.
- R2: A configuration write to an offset from 0x59 to 0x5F stores the byte, and a read of that offset returns it unchanged. Reads of any other offset return 0x00, and writes to other offsets change no stored byte.
- R3: Region i is controlled by the byte at offset 0x59 + i/2. An odd i uses bits 7:4 of that byte and an even i uses bits 3:0. Region 0, the low nibble of 0x59, controls no addresses.
- R4: Region 1 covers 0xF0000–0xFFFFF. Regions 2 to 9 are consecutive 16 KB windows from 0xC0000 to 0xDFFFF. Regions 10 to 13 are consecutive 16 KB windows from 0xE0000 to 0xEFFFF.
- R5: A read in a region goes to DRAM when bit 0 of that region's nibble is 1, and to the ROM side when it is 0.
- R6: A write in a region goes to DRAM when bit 1 of the nibble is 1, and to the ROM side when it is 0. Bits 3:2 of the nibble have no effect.
- R7: Each routed request asserts exactly one of rt_dram and rt_rom. When rt_valid is low, rt_dram, rt_rom, rt_fw and rt_off are all zero.
- R8: An address outside 0xC0000–0xFFFFF that is not in the top firmware window goes to DRAM, for both reads and writes, whatever the attributes hold.
- R9: rt_valid is high in the cycle after a cycle with req_valid high, and low otherwise.
- R10: A read routed to the ROM side at an address within the top min(128 KB, IMG_BYTES) bytes below 0x100000 asserts rt_fw, with rt_off = IMG_BYTES − (0x100000 − address). Other ROM-side legacy accesses, and all writes, give rt_fw = 0.
- R11: An address in the top IMG_BYTES of the address space always goes to the ROM side. A read there asserts rt_fw with rt_off = IMG_BYTES − (2^ADDR_W − address). A write there gives rt_fw = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset, shared by reads and writes |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| req_valid | input | 1 | Memory request valid |
| req_addr | input | ADDR_W | Memory request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| rt_valid | output | 1 | Routing decision valid |
| rt_dram | output | 1 | Access goes to main DRAM |
| rt_rom | output | 1 | Access goes to the ROM/bus side |
| rt_fw | output | 1 | ROM-side read is served by the firmware image |
| rt_off | output | IMG_AW | Byte offset inside the firmware image |

## Verification
A wrong attribute byte or a wrong nibble pick shows up one clock after the request, as a flipped rt_dram/rt_rom pair. This only happens for the region that the faulty state governs. For that reason every region is probed at both of its edges while a single nibble is enabled, so that a neighbour decoded from the wrong half or the wrong byte is also exposed. A faulty alias calculation appears in the same cycle as a wrong rt_off or rt_fw. These are checked at both ends of the low window and the high window, and one byte beyond each.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
   // bit positions inside a region control nibble
   localparam int NIB_RD_EN = 0;
   localparam int NIB_WR_EN = 1;
   // legacy area geometry (fixed by the address map)
   localparam int ONE_MB_LSB = 20;
   localparam int SEG_LSB    = 14;
   localparam int BLK_LSB    = 16;
   localparam int RIDX_W     = 4;
   localparam int N_REGIONS  = 14;

   typedef struct packed {
      logic dram;
      logic rom;
      logic fw;
   } route_t;
endpackage

// File: rtl/shadow_attr_bank.sv
module shadow_attr_bank #(
   parameter int CFG_AW    = 8,
   parameter int N_ATTR    = 7,
   parameter int ATTR_BASE = 'h59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [7:0]        attr_q [N_ATTR]
);
   localparam int LAST = ATTR_BASE + N_ATTR - 1;

   generate
      if (LAST >= (1 << CFG_AW)) begin : g_bad_range
         $error("attribute bytes exceed configuration space");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < N_ATTR; g++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               attr_q[g] <= 8'h00;
            else if (cfg_wr && (cfg_addr == CFG_AW'(ATTR_BASE + g)))
               attr_q[g] <= cfg_wdata;
         end
      end
   endgenerate

   always_comb begin
      cfg_rdata = 8'h00;
      for (int k = 0; k < N_ATTR; k++) begin
         if (cfg_addr == CFG_AW'(ATTR_BASE + k))
            cfg_rdata = attr_q[k];
      end
   end
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
   import shadow_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_legacy,
   output logic [RIDX_W-1:0] ridx
);
   generate
      if (ADDR_W <= ONE_MB_LSB) begin : g_bad_w
         $error("ADDR_W must exceed 20 bits");
      end
   endgenerate

   always_comb begin
      // 0xC0000..0xFFFFF: zero above bit 19, bits 19:18 both set
      in_legacy = (addr[ADDR_W-1:ONE_MB_LSB] == '0) &&
                  (addr[ONE_MB_LSB-1:ONE_MB_LSB-2] == 2'b11);
      if (addr[BLK_LSB+1:BLK_LSB] == 2'b11)
         ridx = RIDX_W'(1);
      else
         ridx = RIDX_W'(2) + RIDX_W'(addr[BLK_LSB+1:SEG_LSB]);
   end
endmodule

// File: rtl/shadow_fw_alias.sv
module shadow_fw_alias
   import shadow_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IMG_BYTES  = 65536,
   parameter int LOW_WIN_MAX = 131072
) (
   input  logic [ADDR_W-1:0]             addr,
   output logic                          low_hit,
   output logic                          high_hit,
   output logic [$clog2(IMG_BYTES)-1:0]  off
);
   localparam int IMG_AW  = $clog2(IMG_BYTES);
   localparam int LOW_WIN = (IMG_BYTES < LOW_WIN_MAX) ? IMG_BYTES : LOW_WIN_MAX;
   localparam logic [ADDR_W-1:0] LOW_TOP  = ADDR_W'(64'h1 << ONE_MB_LSB);
   localparam logic [ADDR_W-1:0] LOW_BASE = LOW_TOP - ADDR_W'(LOW_WIN);

   generate
      if ((1 << IMG_AW) != IMG_BYTES) begin : g_bad_pow2
         $error("IMG_BYTES must be a power of two");
      end
      if (IMG_BYTES > (1 << ONE_MB_LSB)) begin : g_bad_size
         $error("IMG_BYTES must not exceed 1 MB");
      end
   endgenerate

   always_comb begin
      low_hit  = (addr < LOW_TOP) && (addr >= LOW_BASE);
      high_hit = &addr[ADDR_W-1:IMG_AW];
      // both windows end on a multiple of the image size,
      // so the image offset is the low address bits
      off      = addr[IMG_AW-1:0];
   end
endmodule

// File: rtl/shadow_attr_router.sv
module shadow_attr_router
   import shadow_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CFG_AW      = 8,
   parameter int N_ATTR      = 7,
   parameter int ATTR_BASE   = 'h59,
   parameter int IMG_BYTES   = 65536,
   parameter int LOW_WIN_MAX = 131072,
   localparam int IMG_AW     = $clog2(IMG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   output logic              rt_valid,
   output logic              rt_dram,
   output logic              rt_rom,
   output logic              rt_fw,
   output logic [IMG_AW-1:0] rt_off
);
   generate
      if (2 * N_ATTR < N_REGIONS) begin : g_bad_attr
         $error("N_ATTR too small for the region map");
      end
   endgenerate

   logic [7:0]        attr_q [N_ATTR];
   logic              in_legacy;
   logic [RIDX_W-1:0] ridx;
   logic              low_hit, high_hit;
   logic [IMG_AW-1:0] img_off;
   logic [3:0]        nib;
   logic [7:0]        sel_byte;
   logic              en;
   route_t            nxt;

   shadow_attr_bank #(
      .CFG_AW(CFG_AW), .N_ATTR(N_ATTR), .ATTR_BASE(ATTR_BASE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_q(attr_q)
   );

   shadow_region_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(req_addr), .in_legacy(in_legacy), .ridx(ridx)
   );

   shadow_fw_alias #(
      .ADDR_W(ADDR_W), .IMG_BYTES(IMG_BYTES), .LOW_WIN_MAX(LOW_WIN_MAX)
   ) u_alias (
      .addr(req_addr), .low_hit(low_hit), .high_hit(high_hit), .off(img_off)
   );

   always_comb begin
      sel_byte = 8'h00;
      for (int k = 0; k < N_ATTR; k++) begin
         if (ridx[RIDX_W-1:1] == (RIDX_W-1)'(k))
            sel_byte = attr_q[k];
      end
      nib = ridx[0] ? sel_byte[7:4] : sel_byte[3:0];
      en  = req_write ? nib[NIB_WR_EN] : nib[NIB_RD_EN];
   end

   always_comb begin
      nxt = '0;
      if (high_hit) begin
         nxt.rom = 1'b1;
         nxt.fw  = !req_write;
      end else if (!in_legacy) begin
         nxt.dram = 1'b1;
      end else begin
         nxt.dram = en;
         nxt.rom  = !en;
         nxt.fw   = !en && !req_write && low_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rt_valid <= 1'b0;
         rt_dram  <= 1'b0;
         rt_rom   <= 1'b0;
         rt_fw    <= 1'b0;
         rt_off   <= '0;
      end else begin
         rt_valid <= req_valid;
         rt_dram  <= req_valid && nxt.dram;
         rt_rom   <= req_valid && nxt.rom;
         rt_fw    <= req_valid && nxt.fw;
         rt_off   <= (req_valid && nxt.fw) ? img_off : '0;
      end
   end
endmodule

// File: rtl/shadow_attr_router_chk.sv
module shadow_attr_router_chk #(
   parameter int ADDR_W = 32,
   parameter int IMG_AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              rt_valid,
   input logic              rt_dram,
   input logic              rt_rom,
   input logic              rt_fw
);
   logic outside;
   assign outside = !((req_addr[ADDR_W-1:20] == '0) && (req_addr[19:18] == 2'b11)) &&
                    !(&req_addr[ADDR_W-1:IMG_AW]);

   a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      rt_valid |-> $onehot({rt_dram, rt_rom}));

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rt_valid |-> !(rt_dram || rt_rom || rt_fw));

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rt_valid);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rt_valid);

   a_r8_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && outside) |=> rt_dram);

   a_r10_fw_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rt_fw);

   a_r11_high_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (&req_addr[ADDR_W-1:IMG_AW])) |=> rt_rom);
endmodule

bind shadow_attr_router shadow_attr_router_chk #(
   .ADDR_W(ADDR_W), .IMG_AW(IMG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_write(req_write), .rt_valid(rt_valid), .rt_dram(rt_dram),
   .rt_rom(rt_rom), .rt_fw(rt_fw)
);

// File: tb/shadow_attr_router_tb.sv
`timescale 1ns/100ps
module shadow_attr_router_tb;
   localparam int  ADDR_W = 32;
   localparam int  IMG    = 65536;
   localparam int  IMG_AW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [7:0]        cfg_addr = 8'h00;
   logic [7:0]        cfg_wdata = 8'h00;
   logic [7:0]        cfg_rdata;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic              rt_valid, rt_dram, rt_rom, rt_fw;
   logic [IMG_AW-1:0] rt_off;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] mirror [7];

   always #2.5 clk = ~clk;

   shadow_attr_router #(.ADDR_W(ADDR_W), .IMG_BYTES(IMG)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_write(req_write), .rt_valid(rt_valid),
      .rt_dram(rt_dram), .rt_rom(rt_rom), .rt_fw(rt_fw), .rt_off(rt_off)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(logic [7:0] off, logic [7:0] data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = data;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (off >= 8'h59 && off <= 8'h5F) mirror[off - 8'h59] = data;
   endtask

   task automatic cfg_read(logic [7:0] off, output logic [7:0] data);
      @(negedge clk);
      cfg_addr = off;
      #1 data = cfg_rdata;
   endtask

   // drive at a falling edge, registered at the next rising edge,
   // sampled at the falling edge after that
   task automatic expect_route(string req, logic [ADDR_W-1:0] a, logic wr,
                               logic exp_dram, logic exp_fw, logic [IMG_AW-1:0] exp_off);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req, $sformatf("valid @%h", a), rt_valid, 1'b1);
      chk(req, $sformatf("dram @%h w%0d", a, wr), rt_dram, exp_dram);
      chk("R7", $sformatf("rom @%h w%0d", a, wr), rt_rom, !exp_dram);
      chk(req, $sformatf("fw @%h w%0d", a, wr), rt_fw, exp_fw);
      chk(req, $sformatf("off @%h", a), rt_off, exp_off);
   endtask

   task automatic set_all(logic [7:0] v);
      for (int k = 0; k < 7; k++) cfg_write(8'h59 + 8'(k), v);
   endtask

   task automatic set_nib(int r, logic [3:0] v);
      logic [7:0] b;
      b = mirror[r / 2];
      if (r % 2 == 1) b[7:4] = v; else b[3:0] = v;
      cfg_write(8'h59 + 8'(r / 2), b);
   endtask

   function automatic logic [ADDR_W-1:0] reg_lo(int r);
      return (r == 1) ? 32'hF0000 : 32'hC0000 + 32'((r - 2) * 32'h4000);
   endfunction
   function automatic logic [ADDR_W-1:0] reg_hi(int r);
      return (r == 1) ? 32'hFFFFF : reg_lo(r) + 32'h3FFF;
   endfunction

   // expected fw/offset for a ROM-side read in legacy space (64 KB image)
   function automatic logic lo_fw(logic [ADDR_W-1:0] a);
      return a >= 32'hF0000 && a <= 32'hFFFFF;
   endfunction
   function automatic logic [IMG_AW-1:0] lo_off(logic [ADDR_W-1:0] a);
      return IMG_AW'(64'(IMG) - (64'h100000 - 64'(a)));
   endfunction

   task automatic t_reset();
      logic [7:0] d;
      for (int k = 0; k < 7; k++) begin
         cfg_read(8'h59 + 8'(k), d);
         chk("R1", $sformatf("reset byte %0d", k), d, 8'h00);
      end
      chk("R1", "rt_valid at reset", rt_valid, 1'b0);
      expect_route("R1", 32'hC0000, 1'b0, 1'b0, 1'b0, '0);
      expect_route("R1", 32'hE8000, 1'b1, 1'b0, 1'b0, '0);
      expect_route("R1", 32'hFFFFF, 1'b0, 1'b0, 1'b1, 16'hFFFF);
   endtask

   task automatic t_cfg();
      logic [7:0] d;
      cfg_write(8'h5C, 8'hA5);
      cfg_read(8'h5C, d);  chk("R2", "readback 5C", d, 8'hA5);
      cfg_write(8'h5F, 8'h3C);
      cfg_read(8'h5F, d);  chk("R2", "readback 5F", d, 8'h3C);
      cfg_write(8'h60, 8'hFF);
      cfg_write(8'h58, 8'hFF);
      cfg_read(8'h60, d);  chk("R2", "unmapped 60", d, 8'h00);
      cfg_read(8'h58, d);  chk("R2", "unmapped 58", d, 8'h00);
      cfg_read(8'h5F, d);  chk("R2", "5F untouched", d, 8'h3C);
      cfg_read(8'h59, d);  chk("R2", "59 untouched", d, 8'h00);
      set_all(8'h00);
   endtask

   // one region read-enabled at a time, every region probed at both edges
   task automatic t_region_map();
      for (int r = 1; r < 14; r++) begin
         set_all(8'h00);
         set_nib(r, 4'h1);
         for (int q = 1; q < 14; q++) begin
            expect_route("R4", reg_lo(q), 1'b0, q == r,
                         (q != r) && lo_fw(reg_lo(q)), (q != r && lo_fw(reg_lo(q))) ? lo_off(reg_lo(q)) : '0);
            expect_route("R3", reg_hi(q), 1'b0, q == r,
                         (q != r) && lo_fw(reg_hi(q)), (q != r && lo_fw(reg_hi(q))) ? lo_off(reg_hi(q)) : '0);
         end
      end
      // region 0 nibble fully set reaches no address
      set_all(8'h00);
      set_nib(0, 4'hF);
      for (int q = 1; q < 14; q++)
         expect_route("R3", reg_lo(q), 1'b1, 1'b0, 1'b0, '0);
      set_all(8'h00);
   endtask

   task automatic t_steer();
      logic [ADDR_W-1:0] a;
      a = reg_lo(5) + 32'h123;
      set_nib(5, 4'h2);   // write-enable only
      expect_route("R6", a, 1'b1, 1'b1, 1'b0, '0);
      expect_route("R5", a, 1'b0, 1'b0, 1'b0, '0);
      set_nib(5, 4'h3);   // both
      expect_route("R5", a, 1'b0, 1'b1, 1'b0, '0);
      expect_route("R6", a, 1'b1, 1'b1, 1'b0, '0);
      set_nib(5, 4'h1);   // read-enable only
      expect_route("R5", a, 1'b0, 1'b1, 1'b0, '0);
      expect_route("R6", a, 1'b1, 1'b0, 1'b0, '0);
      set_nib(5, 4'hC);   // only the ignored bits
      expect_route("R6", a, 1'b0, 1'b0, 1'b0, '0);
      expect_route("R6", a, 1'b1, 1'b0, 1'b0, '0);
      set_nib(5, 4'h0);
      set_nib(1, 4'h2);   // copy-to-shadow on the top block
      expect_route("R6", 32'hF8000, 1'b1, 1'b1, 1'b0, '0);
      expect_route("R10", 32'hF8000, 1'b0, 1'b0, 1'b1, 16'h8000);
      set_nib(1, 4'h0);
   endtask

   task automatic t_outside();
      set_all(8'h00);
      expect_route("R8", 32'hBFFFF, 1'b0, 1'b1, 1'b0, '0);
      expect_route("R8", 32'hBFFFF, 1'b1, 1'b1, 1'b0, '0);
      expect_route("R8", 32'h100000, 1'b0, 1'b1, 1'b0, '0);
      expect_route("R8", 32'h00000, 1'b1, 1'b1, 1'b0, '0);
      expect_route("R8", 32'hFFFEFFFF, 1'b0, 1'b1, 1'b0, '0);
   endtask

   task automatic t_alias();
      set_all(8'h00);
      expect_route("R10", 32'hF0000, 1'b0, 1'b0, 1'b1, 16'h0000);
      expect_route("R10", 32'hFFFF0, 1'b0, 1'b0, 1'b1, 16'hFFF0);
      expect_route("R10", 32'hEFFFF, 1'b0, 1'b0, 1'b0, '0);
      expect_route("R10", 32'hF0000, 1'b1, 1'b0, 1'b0, '0);
      expect_route("R11", 32'hFFFF0000, 1'b0, 1'b0, 1'b1, 16'h0000);
      expect_route("R11", 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1, 16'hFFFF);
      expect_route("R11", 32'hFFFF8001, 1'b1, 1'b0, 1'b0, '0);
      set_all(8'hFF);     // attributes do not reach the high window
      expect_route("R11", 32'hFFFF1234, 1'b0, 1'b0, 1'b1, 16'h1234);
      set_all(8'h00);
   endtask

   task automatic t_latency();
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h1000; req_write = 1'b0;
      #1 chk("R9", "no output same cycle", rt_valid, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "valid next cycle", rt_valid, 1'b1);
      @(negedge clk);
      chk("R9", "drops after one", rt_valid, 1'b0);
      chk("R7", "idle dram low", rt_dram, 1'b0);
      chk("R7", "idle off zero", rt_off, 16'h0);
   endtask

   initial begin
      for (int k = 0; k < 7; k++) mirror[k] = 8'h00;
      repeat (4) @(negedge clk);
      chk("R1", "rt_valid during reset", rt_valid, 1'b0);
      rst_n = 1'b1;
      t_reset();
      t_cfg();
      t_region_map();
      t_steer();
      t_outside();
      t_alias();
      t_latency();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule